// File: doc/BRIEF.md
# Relocation and Limit Protection Unit

This unit stands between a processor core and its memory port and handles one request at a time. In user mode the core issues a logical address. The unit first compares that address against a limit register. If the address is below the limit, the unit adds a relocation base to it and sends the resulting physical address to memory. If the address is at or above the limit, no memory request is made. Instead, a fatal addressing trap is raised and held until the core acknowledges it. Supervisor-mode requests skip the check and go to memory untranslated, so the supervisor can reach every physical location.

The base and limit values are loaded through a one-cycle register-write port. The port accepts writes only when the writer is in supervisor mode. A write attempted from user mode changes nothing and produces a one-cycle privilege-fault pulse. The core only ever receives read data, a completion or a trap. The physical address appears only on the memory side.

Top module: `reloc_guard`

## Requirements
- R1: After reset, base and limit are both zero. `coreReqReady` is high, and `memReqValid`, `coreRspValid`, `trapValid` and `privFault` are low. The first user request, at any address, therefore traps.
- R2: A user request whose zero-extended address is greater than or equal to the limit raises `trapValid` in the cycle after acceptance, with `trapAddr` equal to the logical address. `memReqValid` stays low for that request.
- R3: A user request whose address is strictly below the limit produces one memory request in the cycle after acceptance. Its `memReqAddr` equals base plus the zero-extended logical address, modulo 2^PAW.
- R4: A supervisor request is never trapped. Its `memReqAddr` equals the logical address zero-extended, whatever the base and limit values are.
- R5: A register write with `cfgWrSuper`=1 loads the base when `cfgWrSel`=0 and the limit when `cfgWrSel`=1, using the full PAW-bit `cfgWrData`. A request accepted on the same clock edge as the write is checked and translated with the values from before that edge. Later requests use the new value.
- R6: Once raised, `trapValid` and `trapAddr` hold until a cycle with `trapAck`=1. While the trap is held, `coreReqReady` is low and no memory request is issued.
- R7: A register write with `cfgWrSuper`=0 leaves base and limit unchanged and makes `privFault` high for exactly the one cycle that follows it.
- R8: `memReqValid` and `memReqAddr` stay stable until `memReqReady` is high. In the cycle after `memRspValid`, `coreRspValid` is high for one cycle and `coreRspRdata` carries the memory data.
- R9: `memReqWrite` and `memReqWdata` carry the direction and write data of the accepted core request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| coreReqValid | input | 1 | Core request present |
| coreReqReady | output | 1 | Unit can accept a request |
| coreReqAddr | input | AW | Logical address |
| coreReqWrite | input | 1 | 1 = write, 0 = read |
| coreReqWdata | input | DW | Write data |
| coreReqSuper | input | 1 | 1 = supervisor mode request |
| coreRspValid | output | 1 | One-cycle completion |
| coreRspRdata | output | DW | Read data returned to the core |
| memReqValid | output | 1 | Memory request present |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | PAW | Physical address |
| memReqWrite | output | 1 | Memory request direction |
| memReqWdata | output | DW | Memory write data |
| memRspValid | input | 1 | Memory completion |
| memRspRdata | input | DW | Memory read data |
| cfgWrValid | input | 1 | Register write strobe |
| cfgWrSel | input | 1 | 0 = base, 1 = limit |
| cfgWrData | input | PAW | Value to load |
| cfgWrSuper | input | 1 | Writer is in supervisor mode |
| trapValid | output | 1 | Addressing trap pending |
| trapAddr | output | AW | Logical address that trapped |
| trapAck | input | 1 | Core acknowledges the trap |
| privFault | output | 1 | Pulse after a user-mode register write |

## Verification
The risky overlap is a supervisor register write and the acceptance of a user request on the same clock edge. The range check and the address sum must both use the values from before that edge.

The bench provokes this overlap twice. In the first case it moves the base while an in-range request is accepted. In the second case it shrinks the limit below an address that the same edge accepts. The expected result is the old physical address in the first case and a forwarded request (not a trap) in the second. The next request at the same address must then show the new base, or must trap under the new limit.

// File: rtl/reloc_guard_pkg.sv
package reloc_guard_pkg;

  // Strobes that the control half hands to the datapath half
  typedef struct packed {
    logic captureReq;  // latch an accepted, forwarded request
    logic raiseTrap;   // latch the faulting logical address
    logic captureRsp;  // latch memory read data
    logic loadBase;    // supervisor write of the relocation base
    logic loadLimit;   // supervisor write of the limit
  } guard_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_AWAIT = 2'd2,
    ST_REPLY = 2'd3
  } guard_state_e;

endpackage

// File: rtl/reloc_guard_ctrl.sv
module reloc_guard_ctrl
  import reloc_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          coreReqValid,
  input  logic          coreReqSuper,
  input  logic          inRange,
  input  logic          memReqReady,
  input  logic          memRspValid,
  input  logic          trapAck,
  input  logic          cfgWrValid,
  input  logic          cfgWrSel,
  input  logic          cfgWrSuper,
  output logic          coreReqReady,
  output logic          coreRspValid,
  output logic          memReqValid,
  output logic          trapValid,
  output logic          privFault,
  output guard_strobe_t strobe
);

  guard_state_e stateQ, stateD;
  logic         trapQ;
  logic         privQ;
  logic         accept;
  logic         fault;

  assign accept = (stateQ == ST_IDLE) && !trapQ && coreReqValid;
  assign fault  = accept && !coreReqSuper && !inRange;

  always_comb begin
    strobe            = '0;
    strobe.captureReq = accept && !fault;
    strobe.raiseTrap  = fault;
    strobe.captureRsp = (stateQ == ST_AWAIT) && memRspValid;
    strobe.loadBase   = cfgWrValid && cfgWrSuper && !cfgWrSel;
    strobe.loadLimit  = cfgWrValid && cfgWrSuper && cfgWrSel;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (accept && !fault) stateD = ST_ISSUE;
      ST_ISSUE: if (memReqReady)      stateD = ST_AWAIT;
      ST_AWAIT: if (memRspValid)      stateD = ST_REPLY;
      ST_REPLY:                       stateD = ST_IDLE;
      default:                        stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      trapQ  <= 1'b0;
      privQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      privQ  <= cfgWrValid && !cfgWrSuper;
      if (fault)        trapQ <= 1'b1;
      else if (trapAck) trapQ <= 1'b0;
    end
  end

  assign coreReqReady = (stateQ == ST_IDLE) && !trapQ;
  assign memReqValid  = (stateQ == ST_ISSUE);
  assign coreRspValid = (stateQ == ST_REPLY);
  assign trapValid    = trapQ;
  assign privFault    = privQ;

endmodule

// File: rtl/reloc_guard_dp.sv
module reloc_guard_dp
  import reloc_guard_pkg::*;
#(
  parameter int AW  = 16,
  parameter int PAW = 20,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  guard_strobe_t  strobe,
  input  logic [AW-1:0]  coreReqAddr,
  input  logic           coreReqSuper,
  input  logic           coreReqWrite,
  input  logic [DW-1:0]  coreReqWdata,
  input  logic [PAW-1:0] cfgWrData,
  input  logic [DW-1:0]  memRspRdata,
  output logic           inRange,
  output logic [PAW-1:0] memReqAddr,
  output logic           memReqWrite,
  output logic [DW-1:0]  memReqWdata,
  output logic [DW-1:0]  coreRspRdata,
  output logic [AW-1:0]  trapAddr,
  output logic [PAW-1:0] baseQ,
  output logic [PAW-1:0] limitQ
);

  logic [PAW-1:0] logicalWide;
  logic [PAW-1:0] relocated;
  logic [PAW-1:0] physD;
  logic [PAW-1:0] physQ;
  logic           writeQ;
  logic [DW-1:0]  wdataQ;
  logic [DW-1:0]  rdataQ;
  logic [AW-1:0]  trapAddrQ;

  assign logicalWide = PAW'(coreReqAddr);
  assign inRange     = logicalWide < limitQ;
  assign relocated   = baseQ + logicalWide;
  assign physD       = coreReqSuper ? logicalWide : relocated;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      limitQ <= '0;
    end else begin
      if (strobe.loadBase)  baseQ  <= cfgWrData;
      if (strobe.loadLimit) limitQ <= cfgWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physQ     <= '0;
      writeQ    <= 1'b0;
      wdataQ    <= '0;
      rdataQ    <= '0;
      trapAddrQ <= '0;
    end else begin
      if (strobe.captureReq) begin
        physQ  <= physD;
        writeQ <= coreReqWrite;
        wdataQ <= coreReqWdata;
      end
      if (strobe.raiseTrap)  trapAddrQ <= coreReqAddr;
      if (strobe.captureRsp) rdataQ    <= memRspRdata;
    end
  end

  assign memReqAddr   = physQ;
  assign memReqWrite  = writeQ;
  assign memReqWdata  = wdataQ;
  assign coreRspRdata = rdataQ;
  assign trapAddr     = trapAddrQ;

endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
  import reloc_guard_pkg::*;
#(
  parameter int AW  = 16,
  parameter int PAW = 20,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           coreReqValid,
  output logic           coreReqReady,
  input  logic [AW-1:0]  coreReqAddr,
  input  logic           coreReqWrite,
  input  logic [DW-1:0]  coreReqWdata,
  input  logic           coreReqSuper,
  output logic           coreRspValid,
  output logic [DW-1:0]  coreRspRdata,
  output logic           memReqValid,
  input  logic           memReqReady,
  output logic [PAW-1:0] memReqAddr,
  output logic           memReqWrite,
  output logic [DW-1:0]  memReqWdata,
  input  logic           memRspValid,
  input  logic [DW-1:0]  memRspRdata,
  input  logic           cfgWrValid,
  input  logic           cfgWrSel,
  input  logic [PAW-1:0] cfgWrData,
  input  logic           cfgWrSuper,
  output logic           trapValid,
  output logic [AW-1:0]  trapAddr,
  input  logic           trapAck,
  output logic           privFault
);

  guard_strobe_t  strobe;
  logic           inRange;
  logic [PAW-1:0] baseQ;
  logic [PAW-1:0] limitQ;

  reloc_guard_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .coreReqValid (coreReqValid),
    .coreReqSuper (coreReqSuper),
    .inRange      (inRange),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .trapAck      (trapAck),
    .cfgWrValid   (cfgWrValid),
    .cfgWrSel     (cfgWrSel),
    .cfgWrSuper   (cfgWrSuper),
    .coreReqReady (coreReqReady),
    .coreRspValid (coreRspValid),
    .memReqValid  (memReqValid),
    .trapValid    (trapValid),
    .privFault    (privFault),
    .strobe       (strobe)
  );

  reloc_guard_dp #(.AW(AW), .PAW(PAW), .DW(DW)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .coreReqAddr  (coreReqAddr),
    .coreReqSuper (coreReqSuper),
    .coreReqWrite (coreReqWrite),
    .coreReqWdata (coreReqWdata),
    .cfgWrData    (cfgWrData),
    .memRspRdata  (memRspRdata),
    .inRange      (inRange),
    .memReqAddr   (memReqAddr),
    .memReqWrite  (memReqWrite),
    .memReqWdata  (memReqWdata),
    .coreRspRdata (coreRspRdata),
    .trapAddr     (trapAddr),
    .baseQ        (baseQ),
    .limitQ       (limitQ)
  );

endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
  parameter int AW  = 16,
  parameter int PAW = 20
) (
  input logic           clk,
  input logic           rstN,
  input logic           coreReqValid,
  input logic           coreReqReady,
  input logic [AW-1:0]  coreReqAddr,
  input logic           coreReqSuper,
  input logic           memReqValid,
  input logic           memReqReady,
  input logic [PAW-1:0] memReqAddr,
  input logic           trapValid,
  input logic [AW-1:0]  trapAddr,
  input logic           trapAck,
  input logic           cfgWrValid,
  input logic           cfgWrSuper,
  input logic           privFault,
  input logic [PAW-1:0] baseQ,
  input logic [PAW-1:0] limitQ
);

  logic           taken;
  logic [PAW-1:0] wideAddr;
  logic [PAW-1:0] expectSum;

  assign taken     = coreReqValid && coreReqReady;
  assign wideAddr  = PAW'(coreReqAddr);
  assign expectSum = baseQ + wideAddr;

  // R1
  always_comb begin
    if (!rstN) begin
      reset_idle_chk: assert (!memReqValid && !trapValid && coreReqReady);
    end
  end

  // R2
  user_out_of_range_traps_chk: assert property (@(posedge clk) disable iff (!rstN)
    taken && !coreReqSuper && (wideAddr >= limitQ)
    |=> trapValid && !memReqValid && (trapAddr == $past(coreReqAddr)));

  // R3
  user_in_range_relocates_chk: assert property (@(posedge clk) disable iff (!rstN)
    taken && !coreReqSuper && (wideAddr < limitQ)
    |=> memReqValid && !trapValid && (memReqAddr == $past(expectSum)));

  // R4
  super_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    taken && coreReqSuper
    |=> memReqValid && !trapValid && (memReqAddr == $past(wideAddr)));

  // R6
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapValid && !trapAck |=> trapValid && $stable(trapAddr) && !coreReqReady);

  // R6
  trap_blocks_memory_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> !memReqValid);

  // R7
  user_cfg_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrValid && !cfgWrSuper |=> privFault && $stable(baseQ) && $stable(limitQ));

  // R8
  mem_req_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

endmodule

bind reloc_guard reloc_guard_chk #(.AW(AW), .PAW(PAW)) u_chk (.*);

// File: tb/reloc_guard_tb.sv
module reloc_guard_tb;

  localparam int AW  = 16;
  localparam int PAW = 20;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           coreReqValid = 1'b0;
  logic           coreReqReady;
  logic [AW-1:0]  coreReqAddr = '0;
  logic           coreReqWrite = 1'b0;
  logic [DW-1:0]  coreReqWdata = '0;
  logic           coreReqSuper = 1'b0;
  logic           coreRspValid;
  logic [DW-1:0]  coreRspRdata;
  logic           memReqValid;
  logic           memReqReady = 1'b0;
  logic [PAW-1:0] memReqAddr;
  logic           memReqWrite;
  logic [DW-1:0]  memReqWdata;
  logic           memRspValid = 1'b0;
  logic [DW-1:0]  memRspRdata = '0;
  logic           cfgWrValid = 1'b0;
  logic           cfgWrSel = 1'b0;
  logic [PAW-1:0] cfgWrData = '0;
  logic           cfgWrSuper = 1'b0;
  logic           trapValid;
  logic [AW-1:0]  trapAddr;
  logic           trapAck = 1'b0;
  logic           privFault;

  always #2.5 clk = ~clk;

  reloc_guard #(.AW(AW), .PAW(PAW), .DW(DW)) u_dut (.*);

  typedef struct packed {
    logic           isTrap;
    logic [AW-1:0]  addr;
    logic [PAW-1:0] phys;
    logic           wr;
    logic [DW-1:0]  wd;
  } exp_t;

  exp_t           expQ[$];
  int             nChecks = 0;
  int             nFail = 0;
  logic [PAW-1:0] lastPhys = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] memData(input logic [PAW-1:0] a);
    return 32'hA500_0000 | DW'(a);
  endfunction

  // Memory model: one stall cycle, response one cycle after the handshake
  initial begin
    logic waited = 1'b0;
    logic pend = 1'b0;
    logic [DW-1:0] pendData = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pend) begin
        memRspValid = 1'b1;
        memRspRdata = pendData;
        pend = 1'b0;
      end
      memReqReady = 1'b0;
      if (memReqValid) begin
        if (waited) begin
          memReqReady = 1'b1;
          waited = 1'b0;
          pend = 1'b1;
          pendData = memData(memReqAddr);
        end else begin
          waited = 1'b1;
        end
      end
    end
  end

  // Monitor: pops the scoreboard as memory requests and traps appear
  initial begin
    logic prevTrap = 1'b0;
    logic seenMem = 1'b0;
    logic [PAW-1:0] firstAddr = '0;
    forever begin
      @(negedge clk);
      #1;
      if (memReqValid && !seenMem) begin
        exp_t e;
        seenMem = 1'b1;
        firstAddr = memReqAddr;
        if (expQ.size() == 0) begin
          check("R2 unexpected memory request", 1, 0);
        end else begin
          e = expQ.pop_front();
          check("R2 forwarded but trap expected", 64'(e.isTrap), 0);
          check("R3/R4 physical address", 64'(memReqAddr), 64'(e.phys));
          check("R9 write flag", 64'(memReqWrite), 64'(e.wr));
          if (e.wr) check("R9 write data", 64'(memReqWdata), 64'(e.wd));
          lastPhys = e.phys;
        end
      end
      if (memReqValid && memReqReady) begin
        check("R8 address stable until ready", 64'(memReqAddr), 64'(firstAddr));
        seenMem = 1'b0;
      end
      if (trapValid && !prevTrap) begin
        exp_t e;
        if (expQ.size() == 0) begin
          check("R2 unexpected trap", 1, 0);
        end else begin
          e = expQ.pop_front();
          check("R2 trap expected", 64'(e.isTrap), 1);
          check("R2 trap address", 64'(trapAddr), 64'(e.addr));
        end
      end
      if (coreRspValid) check("R8 response data", 64'(coreRspRdata), 64'(memData(lastPhys)));
      prevTrap = trapValid;
    end
  end

  // Driver: one request, optionally with a register write on the same edge
  task automatic issue(input logic [AW-1:0] a, input logic sup, input logic wr,
                       input logic [DW-1:0] wd, input logic expTrap,
                       input logic [PAW-1:0] expPhys, input logic doCfg,
                       input logic sel, input logic [PAW-1:0] cdata);
    exp_t e;
    e.isTrap = expTrap; e.addr = a; e.phys = expPhys; e.wr = wr; e.wd = wd;
    expQ.push_back(e);
    @(negedge clk);
    coreReqValid = 1'b1; coreReqAddr = a; coreReqSuper = sup;
    coreReqWrite = wr; coreReqWdata = wd;
    if (doCfg) begin
      cfgWrValid = 1'b1; cfgWrSel = sel; cfgWrData = cdata; cfgWrSuper = 1'b1;
    end
    while (!coreReqReady) @(negedge clk);
    @(negedge clk);
    coreReqValid = 1'b0; cfgWrValid = 1'b0;
    if (expTrap) begin
      while (!trapValid) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check("R6 trap held", 64'(trapValid), 1);
        check("R6 ready low during trap", 64'(coreReqReady), 0);
      end
      trapAck = 1'b1;
      @(negedge clk);
      trapAck = 1'b0;
      check("R6 trap cleared by ack", 64'(trapValid), 0);
      check("R6 ready after ack", 64'(coreReqReady), 1);
    end else begin
      while (!coreRspValid) @(negedge clk);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [PAW-1:0] d, input logic sup);
    @(negedge clk);
    cfgWrValid = 1'b1; cfgWrSel = sel; cfgWrData = d; cfgWrSuper = sup;
    @(negedge clk);
    cfgWrValid = 1'b0;
    check("R7 privilege fault pulse", 64'(privFault), 64'(!sup));
    @(negedge clk);
    check("R7 privilege fault one cycle", 64'(privFault), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready after reset", 64'(coreReqReady), 1);
    check("R1 no memory request", 64'(memReqValid), 0);
    check("R1 no trap", 64'(trapValid), 0);
    check("R1 no response", 64'(coreRspValid), 0);
    check("R1 no privilege fault", 64'(privFault), 0);
    // R1 zero limit: address 0 traps
    issue(16'h0000, 0, 0, 0, 1, 0, 0, 0, 0);
    // R4 supervisor bypass before programming
    issue(16'h1234, 1, 0, 0, 0, 20'h01234, 0, 0, 0);
    // R5 program base and limit
    cfgWrite(0, 20'h30000, 1);
    cfgWrite(1, 20'h01000, 1);
    // R3 in range at top edge, R2 equal and far above
    issue(16'h0FFF, 0, 0, 0, 0, 20'h30FFF, 0, 0, 0);
    issue(16'h1000, 0, 0, 0, 1, 0, 0, 0, 0);
    issue(16'hFFFF, 0, 0, 0, 1, 0, 0, 0, 0);
    // R9 write forwarding
    issue(16'h0010, 0, 1, 32'hDEAD_BEEF, 0, 20'h30010, 0, 0, 0);
    // R7 user register write ignored
    cfgWrite(0, 20'h00000, 0);
    cfgWrite(1, 20'hFFFFF, 0);
    issue(16'h0020, 0, 0, 0, 0, 20'h30020, 0, 0, 0);
    issue(16'h2000, 0, 0, 0, 1, 0, 0, 0, 0);
    // R4 supervisor ignores limit and base
    issue(16'hFFFF, 1, 0, 0, 0, 20'h0FFFF, 0, 0, 0);
    // R5 base written on the same edge: old base applies, then new
    issue(16'h0100, 0, 0, 0, 0, 20'h30100, 1, 0, 20'h50000);
    issue(16'h0100, 0, 0, 0, 0, 20'h50100, 0, 0, 0);
    // R3 wraparound modulo 2^PAW
    cfgWrite(0, 20'hFFF00, 1);
    cfgWrite(1, 20'h0FFFF, 1);
    issue(16'h0200, 0, 0, 0, 0, 20'h00100, 0, 0, 0);
    // R5 limit shrunk on the same edge: old limit applies, then new
    issue(16'h0180, 0, 0, 0, 0, 20'h00080, 1, 1, 20'h00100);
    issue(16'h0180, 0, 0, 0, 1, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", 64'(expQ.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule